// File: doc/BRIEF.md
# Hypervisor-Exit Processor State Updater

This block holds the part of a processor's architectural state that changes when control passes from a guest back to its hypervisor. That state is the instruction pointer, the stack pointer, the flags register, the activity state and three event-blocking flags. The blocking flags are the interrupt-enable shadow, the stack-segment-load shadow and non-maskable-interrupt (NMI) blocking. An exit is requested by a single-cycle strobe. The strobe comes with the hypervisor's instruction-pointer and stack-pointer values and an exit cause code. All of the state is written on the clock edge that samples the strobe.

While the guest runs, the rest of the core moves the non-pointer state through a run-time load port. Examples are a halt instruction, an interrupt-enable shadow, or an NMI return that clears NMI blocking. An exit overrides that port. On exit the flags register takes a fixed value with only bit 1 set, and the activity state returns to active. Both shadows are cleared. NMI blocking is set only when the cause code names an NMI; otherwise it keeps its value. One cycle after each exit the block raises a completion pulse. All outputs are registers and hold between updates.

Top module: `hx_exit_updater`

## Requirements
- R1: A synchronous active-low reset sets the instruction pointer and stack pointer to zero and the flags to 0x2. It sets the activity state to active (code 0), clears all three blocking flags and drops the completion pulse.
- R2: On the edge that samples `exit_valid` high, `cpu_ip` takes `host_ip` and `cpu_sp` takes `host_sp`.
- R3: On every exit, `cpu_flags` becomes 0x0000_0000_0000_0002, whatever its previous value.
- R4: On every exit, `cpu_act` becomes 0 (active), whatever its previous value. The codes are 0 active, 1 halted, 2 shutdown and 3 waiting for a startup signal.
- R5: On every exit, both `irq_shadow` and `ss_shadow` become 0.
- R6: An exit whose `exit_cause` equals parameter `NMI_CAUSE` (default 0) sets `nmi_block` to 1.
- R7: An exit with any other cause leaves `nmi_block` at its previous value.
- R8: `update_done` is high for exactly the cycle after each edge that samples an exit, and low after edges that sample none.
- R9: With `run_load` high and no exit, the flags, activity state and three blocking flags take the `run_*` inputs on that edge. The instruction and stack pointers are left unchanged.
- R10: When `exit_valid` and `run_load` are high together, the `run_load` request has no effect: every field takes its exit value.
- R11: Without an exit, `cpu_ip` and `cpu_sp` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exit_valid | input | 1 | Single-cycle exit strobe |
| exit_cause | input | CAUSE_W | Exit cause code |
| host_ip | input | XLEN | Hypervisor instruction pointer to load |
| host_sp | input | XLEN | Hypervisor stack pointer to load |
| run_load | input | 1 | Run-time load strobe for the non-pointer state |
| run_flags | input | XLEN | Flags value for a run-time load |
| run_act | input | 2 | Activity code for a run-time load |
| run_irq_shadow | input | 1 | Interrupt-enable shadow for a run-time load |
| run_ss_shadow | input | 1 | Stack-segment shadow for a run-time load |
| run_nmi_block | input | 1 | NMI blocking for a run-time load |
| cpu_ip | output | XLEN | Current instruction pointer |
| cpu_sp | output | XLEN | Current stack pointer |
| cpu_flags | output | XLEN | Current flags register |
| cpu_act | output | 2 | Current activity code |
| irq_shadow | output | 1 | Interrupt-enable shadow flag |
| ss_shadow | output | 1 | Stack-segment-load shadow flag |
| nmi_block | output | 1 | NMI blocking flag |
| update_done | output | 1 | Pulse one cycle after an exit |

## Verification
The hardest cases to reach are a non-NMI exit that must keep NMI blocking set, and an exit out of shutdown or the startup wait. An exit rewrites the very state these cases depend on, so each must be set up beforehand. The stimulus therefore uses the run-time load port before every exit, once for each of the 32 combinations of activity code and blocking flags. Each combination is followed by an exit with every one of the 64 cause codes. A short directed part then drives `run_load` and `exit_valid` in the same cycle, with both NMI and non-NMI causes.

// File: rtl/hx_pkg.sv
// Package: shared types for the hypervisor-exit state updater.
// Assumes: activity codes are 2 bits wide and 0 means "active".
package hx_pkg;

    typedef enum logic [1:0] {
        ACT_RUN        = 2'd0,
        ACT_HALT       = 2'd1,
        ACT_SHUTDOWN   = 2'd2,
        ACT_WAIT_START = 2'd3
    } act_e;

    typedef struct packed {
        logic irq_shadow;
        logic ss_shadow;
        logic nmi_block;
    } blk_t;

    localparam int FLAGS_FIXED_BIT = 1;

endpackage

// File: rtl/hx_cause_decode.sv
// Module: hx_cause_decode
// Classifies an exit cause code. It flags whether the exit was caused
// directly by a non-maskable interrupt.
// Assumes: exactly one code value, NMI_CAUSE, denotes a direct NMI exit.
module hx_cause_decode #(
    parameter int CAUSE_W   = 6,
    parameter int NMI_CAUSE = 0
) (
    input  logic [CAUSE_W-1:0] cause,
    output logic               is_nmi
);

    localparam logic [CAUSE_W-1:0] NMI_CODE = CAUSE_W'(NMI_CAUSE);

    // Compare the cause code with the NMI code.
    always_comb begin
        is_nmi = (cause == NMI_CODE);
    end

endmodule

// File: rtl/hx_ptr_regs.sv
// Module: hx_ptr_regs
// Holds the instruction-pointer and stack-pointer registers. Both load
// together on an exit and hold otherwise.
// Assumes: synchronous active-low reset; pointers reset to zero.
module hx_ptr_regs #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] ip_in,
    input  logic [XLEN-1:0] sp_in,
    output logic [XLEN-1:0] ip_q,
    output logic [XLEN-1:0] sp_q
);

    localparam int NPTR = 2;

    logic [XLEN-1:0] d_arr [NPTR];
    logic [XLEN-1:0] q_arr [NPTR];

    // Gather the pointer inputs into an array.
    always_comb begin
        d_arr[0] = ip_in;
        d_arr[1] = sp_in;
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        // Pointer register g: reset to zero, load on an exit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_arr[g] <= '0;
            end else if (load) begin
                q_arr[g] <= d_arr[g];
            end
        end
    end

    // Drive the outputs from the register array.
    always_comb begin
        ip_q = q_arr[0];
        sp_q = q_arr[1];
    end

endmodule

// File: rtl/hx_mode_state.sv
// Module: hx_mode_state
// Holds the flags register, the activity state, the three event-blocking
// flags and the completion pulse. An exit overrides the run-time load.
// Assumes: exit_fire is a single-cycle strobe; exit_nmi is valid with it.
module hx_mode_state
    import hx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exit_fire,
    input  logic            exit_nmi,
    input  logic            run_load,
    input  logic [XLEN-1:0] run_flags,
    input  act_e            run_act,
    input  blk_t            run_blk,
    output logic [XLEN-1:0] flags_q,
    output act_e            act_q,
    output blk_t            blk_q,
    output logic            done_q
);

    localparam logic [XLEN-1:0] FLAGS_FIXED = XLEN'(1) << FLAGS_FIXED_BIT;

    logic [XLEN-1:0] flags_d;
    act_e            act_d;
    blk_t            blk_d;

    // Choose the next state: exit first, then run-time load, else hold.
    always_comb begin
        flags_d = flags_q;
        act_d   = act_q;
        blk_d   = blk_q;
        if (exit_fire) begin
            flags_d          = FLAGS_FIXED;
            act_d            = ACT_RUN;
            blk_d.irq_shadow = 1'b0;
            blk_d.ss_shadow  = 1'b0;
            blk_d.nmi_block  = blk_q.nmi_block | exit_nmi;
        end else if (run_load) begin
            flags_d = run_flags;
            act_d   = run_act;
            blk_d   = run_blk;
        end
    end

    // State registers with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAGS_FIXED;
            act_q   <= ACT_RUN;
            blk_q   <= '0;
        end else begin
            flags_q <= flags_d;
            act_q   <= act_d;
            blk_q   <= blk_d;
        end
    end

    // Completion pulse: high in the cycle after an exit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= exit_fire;
        end
    end

endmodule

// File: rtl/hx_exit_updater.sv
// Module: hx_exit_updater (top)
// Updates the processor's pointers, flags, activity state and event
// blocking when control returns from a guest to its hypervisor.
// Assumes: exit_valid is a single-cycle strobe; all outputs are registered.
module hx_exit_updater
    import hx_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int CAUSE_W   = 6,
    parameter int NMI_CAUSE = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exit_valid,
    input  logic [CAUSE_W-1:0] exit_cause,
    input  logic [XLEN-1:0]    host_ip,
    input  logic [XLEN-1:0]    host_sp,
    input  logic               run_load,
    input  logic [XLEN-1:0]    run_flags,
    input  logic [1:0]         run_act,
    input  logic               run_irq_shadow,
    input  logic               run_ss_shadow,
    input  logic               run_nmi_block,
    output logic [XLEN-1:0]    cpu_ip,
    output logic [XLEN-1:0]    cpu_sp,
    output logic [XLEN-1:0]    cpu_flags,
    output logic [1:0]         cpu_act,
    output logic               irq_shadow,
    output logic               ss_shadow,
    output logic               nmi_block,
    output logic               update_done
);

    logic is_nmi;
    blk_t run_blk;
    blk_t blk_q;
    act_e act_q;

    // Pack the run-time blocking inputs into a struct.
    always_comb begin
        run_blk.irq_shadow = run_irq_shadow;
        run_blk.ss_shadow  = run_ss_shadow;
        run_blk.nmi_block  = run_nmi_block;
    end

    hx_cause_decode #(
        .CAUSE_W  (CAUSE_W),
        .NMI_CAUSE(NMI_CAUSE)
    ) u_decode (
        .cause (exit_cause),
        .is_nmi(is_nmi)
    );

    hx_ptr_regs #(
        .XLEN(XLEN)
    ) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (exit_valid),
        .ip_in(host_ip),
        .sp_in(host_sp),
        .ip_q (cpu_ip),
        .sp_q (cpu_sp)
    );

    hx_mode_state #(
        .XLEN(XLEN)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .exit_fire(exit_valid),
        .exit_nmi (is_nmi),
        .run_load (run_load),
        .run_flags(run_flags),
        .run_act  (act_e'(run_act)),
        .run_blk  (run_blk),
        .flags_q  (cpu_flags),
        .act_q    (act_q),
        .blk_q    (blk_q),
        .done_q   (update_done)
    );

    // Unpack the held state onto the output ports.
    always_comb begin
        cpu_act    = act_q;
        irq_shadow = blk_q.irq_shadow;
        ss_shadow  = blk_q.ss_shadow;
        nmi_block  = blk_q.nmi_block;
    end

endmodule

// File: rtl/hx_exit_checker.sv
// Module: hx_exit_checker
// Temporal checks on the exit updater, attached by bind.
// Assumes: the port names match the top module's ports.
module hx_exit_checker #(
    parameter int XLEN      = 64,
    parameter int CAUSE_W   = 6,
    parameter int NMI_CAUSE = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               exit_valid,
    input logic [CAUSE_W-1:0] exit_cause,
    input logic [XLEN-1:0]    host_ip,
    input logic [XLEN-1:0]    host_sp,
    input logic               run_load,
    input logic [XLEN-1:0]    cpu_ip,
    input logic [XLEN-1:0]    cpu_sp,
    input logic [XLEN-1:0]    cpu_flags,
    input logic [1:0]         cpu_act,
    input logic               irq_shadow,
    input logic               ss_shadow,
    input logic               nmi_block,
    input logic               update_done
);

    localparam logic [XLEN-1:0]    FLAGS_EXIT = XLEN'(2);
    localparam logic [CAUSE_W-1:0] NMI_CODE   = CAUSE_W'(NMI_CAUSE);

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpu_ip == '0 && cpu_sp == '0 && cpu_flags == FLAGS_EXIT
                          && cpu_act == 2'd0 && !nmi_block && !update_done));

    p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> (cpu_ip == $past(host_ip) && cpu_sp == $past(host_sp)));

    p_flags_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> (cpu_flags == FLAGS_EXIT));

    p_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> (cpu_act == 2'd0));

    p_shadow_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> (!irq_shadow && !ss_shadow));

    p_nmi_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_valid && exit_cause == NMI_CODE) |=> nmi_block);

    p_nmi_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_valid && exit_cause != NMI_CODE) |=> (nmi_block == $past(nmi_block)));

    p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> update_done);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !exit_valid |=> !update_done);

    p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !exit_valid |=> ($stable(cpu_ip) && $stable(cpu_sp)));

endmodule

bind hx_exit_updater hx_exit_checker #(
    .XLEN     (XLEN),
    .CAUSE_W  (CAUSE_W),
    .NMI_CAUSE(NMI_CAUSE)
) u_chk (.*);

// File: tb/hx_exit_updater_test.sv
// Bench for hx_exit_updater: it sweeps every activity/blocking combination
// against every cause code, then runs directed cases.
module hx_exit_updater_test;

    localparam int XLEN    = 64;
    localparam int CAUSE_W = 6;
    localparam int NMI_C   = 0;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               exit_valid = 1'b0;
    logic [CAUSE_W-1:0] exit_cause = '0;
    logic [XLEN-1:0]    host_ip = '0;
    logic [XLEN-1:0]    host_sp = '0;
    logic               run_load = 1'b0;
    logic [XLEN-1:0]    run_flags = '0;
    logic [1:0]         run_act = '0;
    logic               run_irq_shadow = 1'b0;
    logic               run_ss_shadow = 1'b0;
    logic               run_nmi_block = 1'b0;
    logic [XLEN-1:0]    cpu_ip, cpu_sp, cpu_flags;
    logic [1:0]         cpu_act;
    logic               irq_shadow, ss_shadow, nmi_block, update_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [XLEN-1:0] e_ip, e_sp, e_flags;
    logic [1:0]      e_act;
    logic            e_irq, e_ss, e_nmi;

    always #5 clk = ~clk;

    hx_exit_updater #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .NMI_CAUSE(NMI_C)) uut (
        .clk(clk), .rst_n(rst_n), .exit_valid(exit_valid), .exit_cause(exit_cause),
        .host_ip(host_ip), .host_sp(host_sp), .run_load(run_load),
        .run_flags(run_flags), .run_act(run_act), .run_irq_shadow(run_irq_shadow),
        .run_ss_shadow(run_ss_shadow), .run_nmi_block(run_nmi_block),
        .cpu_ip(cpu_ip), .cpu_sp(cpu_sp), .cpu_flags(cpu_flags), .cpu_act(cpu_act),
        .irq_shadow(irq_shadow), .ss_shadow(ss_shadow), .nmi_block(nmi_block),
        .update_done(update_done)
    );

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic exp_done);
        chk(req, "ip", cpu_ip, e_ip);
        chk(req, "sp", cpu_sp, e_sp);
        chk(req, "flags", cpu_flags, e_flags);
        chk(req, "act", XLEN'(cpu_act), XLEN'(e_act));
        chk(req, "irq_shadow", XLEN'(irq_shadow), XLEN'(e_irq));
        chk(req, "ss_shadow", XLEN'(ss_shadow), XLEN'(e_ss));
        chk(req, "nmi_block", XLEN'(nmi_block), XLEN'(e_nmi));
        chk(req, "update_done", XLEN'(update_done), XLEN'(exp_done));
    endtask

    // R9: run-time load, no exit; pointers must not move.
    task automatic run_ld(input logic [XLEN-1:0] f, input logic [1:0] a,
                          input logic i, input logic s, input logic n);
        @(negedge clk);
        run_load = 1'b1; run_flags = f; run_act = a;
        run_irq_shadow = i; run_ss_shadow = s; run_nmi_block = n;
        @(posedge clk); #1;
        run_load = 1'b0;
        e_flags = f; e_act = a; e_irq = i; e_ss = s; e_nmi = n;
        chk_state("R9", 1'b0);
    endtask

    // R2-R8: one exit, then an idle cycle to see the pulse drop and the hold.
    task automatic do_exit(input logic [CAUSE_W-1:0] c, input logic [XLEN-1:0] ip,
                           input logic [XLEN-1:0] sp, input bit with_run);
        @(negedge clk);
        exit_valid = 1'b1; exit_cause = c; host_ip = ip; host_sp = sp;
        if (with_run) begin
            run_load = 1'b1; run_flags = '1; run_act = 2'd3;
            run_irq_shadow = 1'b1; run_ss_shadow = 1'b1; run_nmi_block = ~e_nmi;
        end
        @(posedge clk); #1;
        exit_valid = 1'b0; run_load = 1'b0;
        e_ip = ip; e_sp = sp; e_flags = XLEN'(2); e_act = 2'd0;
        e_irq = 1'b0; e_ss = 1'b0;
        if (c == CAUSE_W'(NMI_C)) e_nmi = 1'b1;
        if (with_run) chk_state("R10", 1'b1);
        else if (c == CAUSE_W'(NMI_C)) chk_state("R6", 1'b1);
        else chk_state("R7", 1'b1);
        chk("R2", "ip loaded", cpu_ip, ip);
        chk("R3", "flags forced", cpu_flags, 64'h0000_0000_0000_0002);
        chk("R4", "act active", XLEN'(cpu_act), '0);
        chk("R5", "shadows clear", XLEN'({irq_shadow, ss_shadow}), '0);
        chk("R8", "done high", XLEN'(update_done), XLEN'(1));
        @(negedge clk);
        host_ip = ~ip; host_sp = ~sp;
        @(posedge clk); #1;
        chk("R8", "done low", XLEN'(update_done), '0);
        chk("R11", "ip hold", cpu_ip, e_ip);
        chk("R11", "sp hold", cpu_sp, e_sp);
    endtask

    initial begin
        e_ip = '0; e_sp = '0; e_flags = XLEN'(2); e_act = 2'd0;
        e_irq = 1'b0; e_ss = 1'b0; e_nmi = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_state("R1", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk_state("R1", 1'b0);

        // Sweep: 4 activity codes x 8 blocking patterns x 64 causes.
        for (int st = 0; st < 32; st++) begin
            for (int c = 0; c < 64; c++) begin
                logic [XLEN-1:0] ipv;
                logic [XLEN-1:0] fl;
                ipv = 64'hA5A5_0000_0000_0000 ^ (64'(st * 64 + c) * 64'h0000_0001_0000_1003);
                fl  = 64'hFFFF_0000_0000_00F0 | 64'(st * 7 + c);
                run_ld(fl, 2'(st >> 3), st[2], st[1], st[0]);
                do_exit(CAUSE_W'(c), ipv, {ipv[31:0], ipv[63:32]} ^ 64'h8, 1'b0);
            end
        end

        // R10: run-time load together with an exit, both cause kinds.
        run_ld(64'h0, 2'd1, 1'b1, 1'b1, 1'b0);
        do_exit(CAUSE_W'(5), 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b1);
        chk("R10", "nmi kept 0", XLEN'(nmi_block), '0);
        run_ld(64'h0, 2'd2, 1'b0, 1'b0, 1'b0);
        do_exit(CAUSE_W'(NMI_C), 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1);
        chk("R10", "nmi set", XLEN'(nmi_block), XLEN'(1));
        run_ld(64'h0, 2'd3, 1'b0, 1'b1, 1'b1);
        do_exit(CAUSE_W'(63), 64'hDEAD_0000_BEEF_0000, 64'h0000_CAFE_0000_F00D, 1'b1);
        chk("R10", "nmi kept 1", XLEN'(nmi_block), XLEN'(1));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule